// File: doc/BRIEF.md
# Windowed Sum and Threshold Unit

This block turns nine per-pixel term values, one for each position of a 3x3 window centred on an output pixel, into a single change/no-change decision. The terms are added by a pipelined adder tree, and the total is compared against a programmable threshold. A set bit means the pixel has changed. The unit is fed one pixel per clock in raster order from an upstream stage that produces the terms. Its output bit goes to a downstream writer that stores it into the output frame.

The image is 640 x 480 pixels by default. On the outermost rows and columns, part of the window lies outside the picture. The unit works out from the pixel's row and column which taps are missing and forces them to zero before they are added. No separate mask input is needed. The pixel coordinates and the threshold travel through the pipeline with the data, so each result comes out tagged with its own row and column.

Top module: `win_thresh_unit`

## Requirements
- R1: `out_valid` is asserted exactly three clocks after `in_valid` is sampled high, once for each accepted pixel, and pixels may be accepted on consecutive clocks.
- R2: `out_row` and `out_col` with a result equal the `in_row` and `in_col` sampled together with that pixel.
- R3: Tap k occupies bits [8k+7:8k] of `in_terms`, with k = 3*dr + dc. dr = 0, 1, 2 selects the row above, the same row and the row below. dc = 0, 1, 2 selects the column to the left, the same column and the column to the right. For a pixel away from every border, the sum is the unsigned sum of all nine 8-bit taps.
- R4: `out_change` is 1 only when the sum is strictly greater than `threshold`; a sum equal to the threshold gives 0.
- R5: On row 0 the taps k = 0, 1, 2 are forced to zero.
- R6: On the last row (479) the taps k = 6, 7, 8 are forced to zero.
- R7: On column 0 the taps k = 0, 3, 6 are forced to zero, and on the last column (639) the taps k = 2, 5, 8 are forced to zero.
- R8: At each of the four corners, five taps are forced to zero and only the four taps inside the picture are summed.
- R9: Nine taps of 255 give a sum of 2295 without overflow. Such a pixel reports a change against a threshold of 2294 and no change against 2295.
- R10: After reset `out_valid` and `out_change` are 0, and `out_change` is 0 whenever `out_valid` is 0.
- R11: The threshold is sampled together with the pixel; a change of `threshold` after that clock does not alter that pixel's result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A pixel's taps and coordinates are present |
| in_terms | input | 72 | Nine 8-bit taps, tap k at bits [8k+7:8k] |
| in_row | input | 9 | Row of the centre pixel, 0 to 479 |
| in_col | input | 10 | Column of the centre pixel, 0 to 639 |
| threshold | input | 12 | Decision threshold, unsigned |
| out_valid | output | 1 | A result is present |
| out_change | output | 1 | 1 when the window sum exceeds the threshold |
| out_row | output | 9 | Row of the reported pixel |
| out_col | output | 10 | Column of the reported pixel |

## Verification
The hardest case is confirming which taps were dropped at a border, because only one decision bit comes out. Each border case therefore uses taps with distinct weights and is sent twice, once with the threshold one below the expected masked sum and once equal to it. Together the two results pin the sum down exactly. Corners combine two masks, and a back-to-back stream with mixed coordinates shows that mask and coordinate stay attached to the right pixel.

// File: rtl/wtu_pkg.sv
package wtu_pkg;

    localparam int TAPS         = 9;
    localparam int WIN_SIDE     = 3;
    localparam int DEF_ROWS     = 480;
    localparam int DEF_COLS     = 640;
    localparam int DEF_TERM_W   = 8;

    // vertical position of a tap inside the window: 0 above, 1 centre, 2 below
    function automatic int tap_dr(input int k);
        return k / WIN_SIDE;
    endfunction

    // horizontal position of a tap: 0 left, 1 centre, 2 right
    function automatic int tap_dc(input int k);
        return k % WIN_SIDE;
    endfunction

endpackage

// File: rtl/wtu_border_mask.sv
module wtu_border_mask
    import wtu_pkg::*;
#(
    parameter int ROWS  = DEF_ROWS,
    parameter int COLS  = DEF_COLS,
    parameter int ROW_W = $clog2(ROWS),
    parameter int COL_W = $clog2(COLS)
) (
    input  logic [ROW_W-1:0] row,
    input  logic [COL_W-1:0] col,
    output logic [TAPS-1:0]  keep
);

    localparam logic [ROW_W-1:0] LAST_ROW = ROW_W'(ROWS - 1);
    localparam logic [COL_W-1:0] LAST_COL = COL_W'(COLS - 1);

    logic at_top, at_bottom, at_left, at_right;

    always_comb begin
        at_top    = (row == '0);
        at_bottom = (row == LAST_ROW);
        at_left   = (col == '0);
        at_right  = (col == LAST_COL);
        for (int k = 0; k < TAPS; k++) begin
            keep[k] = !((at_top    && tap_dr(k) == 0) ||
                        (at_bottom && tap_dr(k) == WIN_SIDE - 1) ||
                        (at_left   && tap_dc(k) == 0) ||
                        (at_right  && tap_dc(k) == WIN_SIDE - 1));
        end
    end

endmodule

// File: rtl/wtu_add_level.sv
module wtu_add_level #(
    parameter int N_IN = 9,
    parameter int W    = 12,
    localparam int N_OUT = (N_IN + 1) / 2
) (
    input  logic [N_IN*W-1:0]  din,
    output logic [N_OUT*W-1:0] dout
);

    genvar i;
    generate
        for (i = 0; i < N_IN / 2; i++) begin : g_pair
            assign dout[i*W +: W] = din[(2*i)*W +: W] + din[(2*i+1)*W +: W];
        end
        if (N_IN % 2 == 1) begin : g_odd
            assign dout[(N_OUT-1)*W +: W] = din[(N_IN-1)*W +: W];
        end
    endgenerate

endmodule

// File: rtl/win_thresh_unit.sv
module win_thresh_unit
    import wtu_pkg::*;
#(
    parameter int ROWS   = DEF_ROWS,
    parameter int COLS   = DEF_COLS,
    parameter int TERM_W = DEF_TERM_W,
    localparam int ROW_W = $clog2(ROWS),
    localparam int COL_W = $clog2(COLS),
    localparam int SUM_W = TERM_W + $clog2(TAPS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic [TAPS*TERM_W-1:0] in_terms,
    input  logic [ROW_W-1:0]       in_row,
    input  logic [COL_W-1:0]       in_col,
    input  logic [SUM_W-1:0]       threshold,
    output logic                   out_valid,
    output logic                   out_change,
    output logic [ROW_W-1:0]       out_row,
    output logic [COL_W-1:0]       out_col
);

    localparam int N_L1 = (TAPS + 1) / 2;   // 5
    localparam int N_L2 = (N_L1 + 1) / 2;   // 3
    localparam int N_L3 = (N_L2 + 1) / 2;   // 2
    localparam int N_L4 = (N_L3 + 1) / 2;   // 1

    typedef struct packed {
        // stage 1: masked, widened taps
        logic                   v1;
        logic [ROW_W-1:0]       r1;
        logic [COL_W-1:0]       c1;
        logic [SUM_W-1:0]       t1;
        logic [TAPS*SUM_W-1:0]  a1;
        // stage 2: partial sums after two tree levels
        logic                   v2;
        logic [ROW_W-1:0]       r2;
        logic [COL_W-1:0]       c2;
        logic [SUM_W-1:0]       t2;
        logic [N_L2*SUM_W-1:0]  a2;
        // stage 3: decision
        logic                   v3;
        logic [ROW_W-1:0]       r3;
        logic [COL_W-1:0]       c3;
        logic                   ch3;
    } pipe_t;

    pipe_t pipe_d, pipe_q;

    logic [TAPS-1:0]        keep;
    logic [N_L1*SUM_W-1:0]  lvl1;
    logic [N_L2*SUM_W-1:0]  lvl2;
    logic [N_L3*SUM_W-1:0]  lvl3;
    logic [N_L4*SUM_W-1:0]  lvl4;

    wtu_border_mask #(
        .ROWS (ROWS),
        .COLS (COLS),
        .ROW_W(ROW_W),
        .COL_W(COL_W)
    ) u_mask (
        .row (in_row),
        .col (in_col),
        .keep(keep)
    );

    // first half of the tree, fed from stage 1
    wtu_add_level #(.N_IN(TAPS), .W(SUM_W)) u_lvl1 (.din(pipe_q.a1), .dout(lvl1));
    wtu_add_level #(.N_IN(N_L1), .W(SUM_W)) u_lvl2 (.din(lvl1),      .dout(lvl2));
    // second half of the tree, fed from stage 2
    wtu_add_level #(.N_IN(N_L2), .W(SUM_W)) u_lvl3 (.din(pipe_q.a2), .dout(lvl3));
    wtu_add_level #(.N_IN(N_L3), .W(SUM_W)) u_lvl4 (.din(lvl3),      .dout(lvl4));

    always_comb begin
        pipe_d = pipe_q;

        pipe_d.v1 = in_valid;
        pipe_d.r1 = in_row;
        pipe_d.c1 = in_col;
        pipe_d.t1 = threshold;
        for (int k = 0; k < TAPS; k++) begin
            pipe_d.a1[k*SUM_W +: SUM_W] =
                keep[k] ? SUM_W'(in_terms[k*TERM_W +: TERM_W]) : '0;
        end

        pipe_d.v2 = pipe_q.v1;
        pipe_d.r2 = pipe_q.r1;
        pipe_d.c2 = pipe_q.c1;
        pipe_d.t2 = pipe_q.t1;
        pipe_d.a2 = lvl2;

        pipe_d.v3  = pipe_q.v2;
        pipe_d.r3  = pipe_q.r2;
        pipe_d.c3  = pipe_q.c2;
        pipe_d.ch3 = pipe_q.v2 && (lvl4 > pipe_q.t2);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign out_valid  = pipe_q.v3;
    assign out_change = pipe_q.ch3;
    assign out_row    = pipe_q.r3;
    assign out_col    = pipe_q.c3;

endmodule

// File: rtl/wtu_checker.sv
module wtu_checker
    import wtu_pkg::*;
#(
    parameter int ROWS   = DEF_ROWS,
    parameter int COLS   = DEF_COLS,
    parameter int TERM_W = DEF_TERM_W,
    localparam int ROW_W = $clog2(ROWS),
    localparam int COL_W = $clog2(COLS),
    localparam int SUM_W = TERM_W + $clog2(TAPS)
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   in_valid,
    input logic [TAPS*TERM_W-1:0] in_terms,
    input logic [ROW_W-1:0]       in_row,
    input logic [COL_W-1:0]       in_col,
    input logic [SUM_W-1:0]       threshold,
    input logic                   out_valid,
    input logic                   out_change,
    input logic [ROW_W-1:0]       out_row,
    input logic [COL_W-1:0]       out_col
);

    localparam int MAXT = (1 << TERM_W) - 1;
    localparam logic [SUM_W-1:0] FULL_M1    = SUM_W'(TAPS * MAXT - 1);
    localparam logic [SUM_W-1:0] CORNER_SUM = SUM_W'(4 * MAXT);

    logic all_max, interior;
    assign all_max  = &in_terms;
    assign interior = (in_row != '0) && (in_row != ROW_W'(ROWS - 1)) &&
                      (in_col != '0) && (in_col != COL_W'(COLS - 1));

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ##2 out_valid);                                          // R1
    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ##2 !out_valid);                                        // R1
    AST_COORD_TAG: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ##2 (out_row == $past(in_row, 3) && out_col == $past(in_col, 3))); // R2
    AST_ZERO_SUM_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_terms == '0) |=> ##2 !out_change);                    // R4
    AST_CORNER_PAD: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && all_max && in_row == '0 && in_col == '0 &&
         threshold == CORNER_SUM) |=> ##2 !out_change);                       // R8
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && all_max && interior && threshold == FULL_M1) |=> ##2 out_change); // R9
    AST_CHANGE_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> !out_change);                                          // R10

endmodule

bind win_thresh_unit wtu_checker #(
    .ROWS  (ROWS),
    .COLS  (COLS),
    .TERM_W(TERM_W)
) u_chk (.*);

// File: tb/win_thresh_unit_bench.sv
`timescale 1ns/1ps
module win_thresh_unit_bench;

    localparam int ROWS  = 480;
    localparam int COLS  = 640;
    localparam int TW    = 8;
    localparam int TAPS  = 9;
    localparam int SW    = 12;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic [TAPS*TW-1:0] in_terms = '0;
    logic [8:0]        in_row = '0;
    logic [9:0]        in_col = '0;
    logic [SW-1:0]     threshold = '0;
    logic              out_valid, out_change;
    logic [8:0]        out_row;
    logic [9:0]        out_col;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    win_thresh_unit u_win_thresh_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_terms(in_terms),
        .in_row(in_row), .in_col(in_col), .threshold(threshold),
        .out_valid(out_valid), .out_change(out_change),
        .out_row(out_row), .out_col(out_col)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // expected masked sum, from the tap layout and border rules
    function automatic int model_sum(input logic [TAPS*TW-1:0] t, input int row, input int col);
        int s = 0;
        for (int k = 0; k < TAPS; k++) begin
            int dr = k / 3;
            int dc = k % 3;
            if (!((row == 0 && dr == 0) || (row == ROWS-1 && dr == 2) ||
                  (col == 0 && dc == 0) || (col == COLS-1 && dc == 2)))
                s += int'(t[k*TW +: TW]);
        end
        return s;
    endfunction

    function automatic logic [TAPS*TW-1:0] pattern(input int seed);
        logic [TAPS*TW-1:0] t;
        for (int k = 0; k < TAPS; k++)
            t[k*TW +: TW] = TW'((seed * 37 + k * 53 + 11) & 255);
        return t;
    endfunction

    function automatic logic [TAPS*TW-1:0] weights();
        logic [TAPS*TW-1:0] t;
        for (int k = 0; k < TAPS; k++)
            t[k*TW +: TW] = TW'(1 << (k % 8)) + TW'(k >= 8 ? 100 : 0);
        return t;
    endfunction

    // one isolated pixel; result sampled at the negedge after the third edge
    task automatic send_one(input logic [TAPS*TW-1:0] t, input int row, input int col,
                            input int thr, output logic v, output logic ch,
                            output int r, output int c);
        @(negedge clk);
        in_valid = 1'b1; in_terms = t; in_row = 9'(row); in_col = 10'(col);
        threshold = SW'(thr);
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        v = out_valid; ch = out_change; r = int'(out_row); c = int'(out_col);
    endtask

    // brackets the sum: threshold one below must report change, equal must not
    task automatic bracket(input string req, input logic [TAPS*TW-1:0] t,
                           input int row, input int col);
        logic v, ch; int r, c;
        int s = model_sum(t, row, col);
        send_one(t, row, col, s - 1, v, ch, r, c);
        check({req, " valid"}, int'(v), 1);
        check({req, " change above"}, int'(ch), 1);
        check({req, " row"}, r, row);
        check({req, " col"}, c, col);
        send_one(t, row, col, s, v, ch, r, c);
        check({req, " change equal"}, int'(ch), 0);
    endtask

    task automatic t_reset();
        check("R10 reset valid", int'(out_valid), 0);
        check("R10 reset change", int'(out_change), 0);
    endtask

    task automatic t_interior();
        for (int i = 0; i < 4; i++)
            bracket("R3 R4 interior", pattern(i + 1), 100 + i * 50, 200 + i * 70);
        bracket("R3 interior zero taps", '0 | 72'(1) << 36, 5, 5);
    endtask

    task automatic t_edges();
        bracket("R5 top row", weights(), 0, 300);
        bracket("R6 bottom row", weights(), ROWS - 1, 300);
        bracket("R7 left col", weights(), 240, 0);
        bracket("R7 right col", weights(), 240, COLS - 1);
    endtask

    task automatic t_corners();
        bracket("R8 top-left", weights(), 0, 0);
        bracket("R8 top-right", weights(), 0, COLS - 1);
        bracket("R8 bottom-left", weights(), ROWS - 1, 0);
        bracket("R8 bottom-right", weights(), ROWS - 1, COLS - 1);
    endtask

    task automatic t_overflow();
        logic v, ch; int r, c;
        send_one('1, 10, 10, 2294, v, ch, r, c);
        check("R9 max sum above 2294", int'(ch), 1);
        send_one('1, 10, 10, 2295, v, ch, r, c);
        check("R9 max sum equal 2295", int'(ch), 0);
    endtask

    task automatic t_stream();
        logic [TAPS*TW-1:0] tv[4];
        int rows[4], cols[4];
        rows = '{0, 37, ROWS - 1, 200};
        cols = '{5, 0, 600, COLS - 1};
        for (int p = 0; p < 4; p++) tv[p] = pattern(p + 20);
        for (int cyc = 0; cyc < 8; cyc++) begin
            @(negedge clk);
            if (cyc >= 3 && cyc - 3 < 4) begin
                int p = cyc - 3;
                check("R1 stream valid", int'(out_valid), 1);
                check("R2 stream row", int'(out_row), rows[p]);
                check("R2 stream col", int'(out_col), cols[p]);
                check("R1 stream change", int'(out_change),
                      int'(model_sum(tv[p], rows[p], cols[p]) > 700));
            end else begin
                check("R1 stream idle valid", int'(out_valid), 0);
                check("R10 stream idle change", int'(out_change), 0);
            end
            if (cyc < 4) begin
                in_valid = 1'b1; in_terms = tv[cyc];
                in_row = 9'(rows[cyc]); in_col = 10'(cols[cyc]); threshold = SW'(700);
            end else begin
                in_valid = 1'b0;
            end
        end
    endtask

    task automatic t_thr_capture();
        int s = model_sum(pattern(7), 50, 50);
        @(negedge clk);
        in_valid = 1'b1; in_terms = pattern(7); in_row = 9'd50; in_col = 10'd50;
        threshold = SW'(s);
        @(negedge clk);
        in_valid = 1'b0; threshold = '0;
        @(negedge clk);
        @(negedge clk);
        check("R11 late threshold drop ignored", int'(out_change), 0);
        @(negedge clk);
        in_valid = 1'b1; threshold = SW'(s - 1);
        @(negedge clk);
        in_valid = 1'b0; threshold = 12'hFFF;
        @(negedge clk);
        @(negedge clk);
        check("R11 late threshold raise ignored", int'(out_change), 1);
    endtask

    initial begin
        #(8 * 20000);
        errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_interior();
        t_edges();
        t_corners();
        t_overflow();
        t_stream();
        t_thr_capture();
        repeat (4) @(negedge clk);
        check("R10 idle change", int'(out_change), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule